// File: doc/BRIEF.md
# Integer Adder with Carry and Overflow Flags

This block is the add unit of an integer datapath. On each cycle where the valid strobe is high it adds two operands, either as a plain add or as an add that also folds in the stored carry flag. It registers the sum, updates its own carry and overflow flags, and may raise a range-exception request. The carry flag lives inside the unit, and the add-with-carry form reads it from there. This lets multi-word additions be chained by issuing a plain add for the low word and then add-with-carry for each higher word.

Carry-out comes from comparing the unsigned result with the first operand. A strict less-than is used when no carry is fed in. A less-or-equal is used when a carry is fed in, which covers the wrap from 0 + all-ones + 1. A generate option can build the carry from an extended-width sum instead, and both variants give the same flags. Overflow follows the sign rule on the operands and the result. A range exception is requested when the enable input is high and the new overflow flag is set. Results appear one clock after the strobe, marked by an output valid pulse.

Top module: `add_flag_unit`

## Requirements
- R1: One clock after a cycle with `inValid` high, `outValid` is high for one cycle and `sum` holds opA + opB (+ carry-in) modulo 2^WIDTH.
- R2: With `opSel` = 0 (plain add), the carry flag becomes 1 exactly when the unsigned sum is smaller than opA.
- R3: With `opSel` = 1 (add with carry), the stored carry flag value is added into the sum as an extra 1.
- R4: When a carry of 1 is fed in, the carry flag becomes 1 exactly when the unsigned sum is less than or equal to opA. For example, 0 + all-ones + 1 gives sum 0 with carry 1.
- R5: The overflow flag becomes 1 when both operands have MSB 1 and the sum has MSB 0, or both have MSB 0 and the sum has MSB 1. Otherwise it becomes 0, whatever the carry-in.
- R6: `rangeExc` is a one-cycle pulse, aligned with `outValid`, that is high only when `ovExcEn` was 1 and the new overflow flag is 1.
- R7: In cycles where `inValid` is low, both flags hold and `outValid` and `rangeExc` are 0 on the next cycle, whatever the other inputs are.
- R8: A synchronous active-high reset clears both flags, `sum`, `outValid` and `rangeExc`.
- R9: A plain add ignores the stored carry flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operation strobe |
| opSel | input | 1 | 0 = plain add, 1 = add with stored carry |
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| ovExcEn | input | 1 | Enables the range-exception request on overflow |
| sum | output | WIDTH | Registered sum |
| outValid | output | 1 | Result valid pulse |
| carryFlag | output | 1 | Stored carry flag |
| ovFlag | output | 1 | Stored overflow flag |
| rangeExc | output | 1 | Range-exception request pulse |

## Verification
The bench builds the unit with WIDTH = 32 and the default comparison-based carry. This makes the exact all-ones wrap, the signed boundary 0x7FFFFFFF/0x80000000 and the carry-in edge cases directly reachable as directed vectors. Random operands are biased toward those boundary values, so chained add-with-carry sequences regularly propagate a stored carry. The bench models the carry through a 33-bit sum rather than a comparison, so the two derivations are checked against each other.

// File: rtl/add_flag_pkg.sv
package add_flag_pkg;
  typedef enum logic {
    OP_ADD  = 1'b0,
    OP_ADDC = 1'b1
  } addOp_e;

  typedef struct packed {
    logic capture;   // latch sum and flags this cycle
    logic useCarry;  // fold the stored carry into the sum
    logic excArm;    // exception may fire if overflow results
  } addStrobes_t;
endpackage

// File: rtl/add_flag_control.sv
module add_flag_control
  import add_flag_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic        opSel,
  input  logic        ovExcEn,
  output addStrobes_t strobes,
  output logic        outValid
);
  addOp_e opKind;

  always_comb begin
    opKind           = addOp_e'(opSel);
    strobes.capture  = inValid;
    strobes.useCarry = (opKind == OP_ADDC);
    strobes.excArm   = inValid & ovExcEn;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end
endmodule

// File: rtl/add_flag_datapath.sv
module add_flag_datapath
  import add_flag_pkg::*;
#(
  parameter int WIDTH              = 32,
  parameter bit CARRY_FROM_COMPARE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  addStrobes_t      strobes,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] sum,
  output logic             carryFlag,
  output logic             ovFlag,
  output logic             rangeExc
);
  localparam int MSB = WIDTH - 1;

  logic             carryIn;
  logic [WIDTH-1:0] sumNext;
  logic             carryNext;
  logic             ovNext;

  assign carryIn = strobes.useCarry & carryFlag;

  generate
    if (CARRY_FROM_COMPARE) begin : g_cmpCarry
      assign sumNext   = opA + opB + WIDTH'(carryIn);
      assign carryNext = carryIn ? (sumNext <= opA) : (sumNext < opA);
    end else begin : g_wideCarry
      logic [WIDTH:0] wideSum;
      assign wideSum   = {1'b0, opA} + {1'b0, opB} + (WIDTH+1)'(carryIn);
      assign sumNext   = wideSum[MSB:0];
      assign carryNext = wideSum[WIDTH];
    end
  endgenerate

  assign ovNext = (opA[MSB] == opB[MSB]) && (sumNext[MSB] != opA[MSB]);

  always_ff @(posedge clk) begin
    if (rst) begin
      sum       <= '0;
      carryFlag <= 1'b0;
      ovFlag    <= 1'b0;
      rangeExc  <= 1'b0;
    end else begin
      rangeExc <= strobes.excArm & ovNext;
      if (strobes.capture) begin
        sum       <= sumNext;
        carryFlag <= carryNext;
        ovFlag    <= ovNext;
      end
    end
  end
endmodule

// File: rtl/add_flag_unit.sv
module add_flag_unit
  import add_flag_pkg::*;
#(
  parameter int WIDTH              = 32,
  parameter bit CARRY_FROM_COMPARE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic             opSel,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             ovExcEn,
  output logic [WIDTH-1:0] sum,
  output logic             outValid,
  output logic             carryFlag,
  output logic             ovFlag,
  output logic             rangeExc
);
  addStrobes_t strobes;

  add_flag_control u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .opSel(opSel),
    .ovExcEn(ovExcEn), .strobes(strobes), .outValid(outValid)
  );

  add_flag_datapath #(.WIDTH(WIDTH), .CARRY_FROM_COMPARE(CARRY_FROM_COMPARE)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .opA(opA), .opB(opB),
    .sum(sum), .carryFlag(carryFlag), .ovFlag(ovFlag), .rangeExc(rangeExc)
  );
endmodule

// File: rtl/add_flag_unit_checker.sv
module add_flag_unit_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic             opSel,
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             ovExcEn,
  input logic [WIDTH-1:0] sum,
  input logic             outValid,
  input logic             carryFlag,
  input logic             ovFlag,
  input logic             rangeExc
);
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  assert_add_carry_R2: assert property (@(posedge clk) disable iff (rst)
    (inValid && !opSel) |=> (carryFlag == (sum < $past(opA))));

  assert_plain_sum_R9: assert property (@(posedge clk) disable iff (rst)
    (inValid && !opSel) |=> (sum == WIDTH'($past(opA) + $past(opB))));

  assert_no_ov_mixed_sign_R5: assert property (@(posedge clk) disable iff (rst)
    (inValid && (opA[WIDTH-1] != opB[WIDTH-1])) |=> !ovFlag);

  assert_exc_with_valid_R6: assert property (@(posedge clk) disable iff (rst)
    rangeExc |-> (outValid && ovFlag));

  assert_exc_needs_enable_R6: assert property (@(posedge clk) disable iff (rst)
    (inValid && !ovExcEn) |=> !rangeExc);

  assert_flags_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ($stable(carryFlag) && $stable(ovFlag) && !outValid && !rangeExc));

  assert_reset_clear_R8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!carryFlag && !ovFlag && !outValid && !rangeExc && sum == '0));
endmodule

bind add_flag_unit add_flag_unit_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .opSel(opSel), .opA(opA), .opB(opB),
  .ovExcEn(ovExcEn), .sum(sum), .outValid(outValid), .carryFlag(carryFlag),
  .ovFlag(ovFlag), .rangeExc(rangeExc)
);

// File: tb/add_flag_unit_test.sv
module add_flag_unit_test;
  localparam int W = 32;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic         opSel = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         ovExcEn = 1'b0;
  logic [W-1:0] sum;
  logic         outValid, carryFlag, ovFlag, rangeExc;

  int checks = 0;
  int failures = 0;
  logic mCarry = 1'b0;
  logic mOv = 1'b0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  add_flag_unit #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .inValid(inValid), .opSel(opSel), .opA(opA), .opB(opB),
    .ovExcEn(ovExcEn), .sum(sum), .outValid(outValid), .carryFlag(carryFlag),
    .ovFlag(ovFlag), .rangeExc(rangeExc)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pickOperand();
    case ($urandom_range(0, 5))
      0: return '0;
      1: return '1;
      2: return {1'b0, {(W-1){1'b1}}};
      3: return {1'b1, {(W-1){1'b0}}};
      default: return $urandom;
    endcase
  endfunction

  task automatic runOp(input logic op, input logic [W-1:0] a, input logic [W-1:0] b, input logic en);
    logic [W:0]   wide;
    logic         cin;
    logic [W-1:0] eS;
    logic         eC, eV;
    string        ctag;
    @(negedge clk);
    inValid = 1'b1; opSel = op; opA = a; opB = b; ovExcEn = en;
    cin  = op & mCarry;
    wide = {1'b0, a} + {1'b0, b} + (W+1)'(cin);
    eS   = wide[W-1:0];
    eC   = wide[W];
    eV   = (a[W-1] == b[W-1]) && (eS[W-1] != a[W-1]);
    ctag = op ? (cin ? "R4 carry" : "R3 carry") : "R2 carry";
    @(negedge clk);
    inValid = 1'b0;
    check(op ? "R3 sum" : "R9 sum", sum, eS);
    check("R1 outValid", W'(outValid), W'(1));
    check(ctag, W'(carryFlag), W'(eC));
    check("R5 overflow", W'(ovFlag), W'(eV));
    check("R6 rangeExc", W'(rangeExc), W'(en & eV));
    mCarry = eC;
    mOv = eV;
  endtask

  task automatic idleCycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0; opSel = 1'($urandom); opA = $urandom; opB = $urandom; ovExcEn = 1'b1;
      @(negedge clk);
      check("R7 carry hold", W'(carryFlag), W'(mCarry));
      check("R7 ov hold", W'(ovFlag), W'(mOv));
      check("R7 outValid low", W'(outValid), W'(0));
      check("R7 rangeExc low", W'(rangeExc), W'(0));
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R8 reset sum", sum, '0);
    check("R8 reset carry", W'(carryFlag), W'(0));
    check("R8 reset ov", W'(ovFlag), W'(0));
    check("R8 reset outValid", W'(outValid), W'(0));

    // R4: set carry via wrap, then 0 + all-ones + 1 must wrap with carry
    runOp(1'b0, '1, 32'h1, 1'b0);
    runOp(1'b1, '0, '1, 1'b0);
    // R9: plain add with stored carry set ignores it
    runOp(1'b0, 32'h1, 32'h1, 1'b0);
    // R5: overflow with carry-in, both nonnegative
    runOp(1'b0, '1, 32'h1, 1'b0);
    runOp(1'b1, 32'h7FFF_FFFF, 32'h0, 1'b1);
    // R6: overflow with enable off gives no exception
    runOp(1'b0, 32'h8000_0000, 32'h8000_0000, 1'b0);
    runOp(1'b0, 32'h8000_0000, 32'h8000_0000, 1'b1);
    idleCycles(3);

    // R8: reset after flags set
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R8 reset carry again", W'(carryFlag), W'(0));
    check("R8 reset ov again", W'(ovFlag), W'(0));
    check("R8 reset rangeExc", W'(rangeExc), W'(0));
    mCarry = 1'b0; mOv = 1'b0;

    for (int k = 0; k < 3000; k++) begin
      runOp(1'($urandom), pickOperand(), pickOperand(), 1'($urandom));
      if ($urandom_range(0, 9) == 0) idleCycles(1);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule